// File: doc/BRIEF.md
# Prefixed Opcode Sequencer

This block sits behind an instruction-fetch port and walks the incoming byte stream one byte per handshake. It recognises the four prefix bytes of an 8-bit processor family with paged opcodes, follows prefix chains to the opcode that ends the instruction, and emits one record per instruction. Each record gives the start address, the opcode page, the selected index register, the signed displacement, the final opcode and the number of bytes consumed.

A downstream execution stage takes the records through a valid/ready pair. The sequencer also forms the effective address of indexed bit operations from the selected index register input. Operand bytes after the opcode (immediates) are not consumed here; the next byte after an emitted record always starts a new instruction.

Top module: `pfx_seq`

## Requirements
- R1: After reset `rec_valid_o` is 0, `byte_ready_o` is 1, and the first accepted byte has address `RESET_PC` (default 0).
- R2: A first byte that is none of 0xCB, 0xED, 0xDD, 0xFD ends an instruction on page 0 (base) with length 1, index 0 and displacement 0.
- R3: Byte 0xCB followed by any byte gives page 1 (bit page), length 2, opcode equal to the second byte, index 0.
- R4: Byte 0xED followed by a byte other than 0xED gives page 2 (extended), length 2, and the illegal flag set unless the opcode has bits [7:6] = 01, or bits [7:5] = 101 with bit 2 clear; the byte after it starts a new instruction.
- R5: When 0xED follows 0xED, the first one is dropped and the instruction start moves to the address of the second one.
- R6: 0xDD selects index 1 and 0xFD selects index 2; a following byte other than 0xDD, 0xFD, 0xCB gives page 3 (indexed), length 2, with that index.
- R7: When 0xDD or 0xFD follows 0xDD or 0xFD, the earlier prefix is dropped; the last one sets the index and the start address.
- R8: 0xDD or 0xFD, then 0xCB, then a displacement byte d, then an opcode byte gives page 4 (indexed bit), length 4, displacement d and opcode equal to the fourth byte.
- R9: On page 4, `rec_ea_o` equals the selected index input plus d sign-extended (bit 7 set means d − 256), modulo 2^ADDR_W; on other pages it is 0.
- R10: The record start address is the address of the instruction's first kept byte, addresses counting up by one per accepted byte.
- R11: While `rec_valid_o` is 1 and `rec_ready_i` is 0, the record fields hold and `byte_ready_o` is 0.
- R12: The illegal flag is only ever set on page 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Fetched byte |
| byte_valid_i | input | 1 | Fetched byte is valid |
| byte_ready_o | output | 1 | Sequencer accepts the byte this cycle |
| idx_a_i | input | ADDR_W | Index register 1 value |
| idx_b_i | input | ADDR_W | Index register 2 value |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_pc_o | output | ADDR_W | Instruction start address |
| rec_page_o | output | 3 | Opcode page: 0 base, 1 bit, 2 extended, 3 indexed, 4 indexed bit |
| rec_idx_o | output | 2 | Index select: 0 none, 1 first, 2 second |
| rec_disp_o | output | 8 | Displacement byte (page 4 only, else 0) |
| rec_op_o | output | 8 | Final opcode byte |
| rec_len_o | output | 3 | Bytes consumed, 1 to 4 |
| rec_illegal_o | output | 1 | Unrecognised extended opcode |
| rec_ea_o | output | ADDR_W | Effective address of an indexed bit operation |

## Verification
A wrong internal state shows at the ports on the very next record: a stuck prefix state mislabels the page or length, a stale index choice flips `rec_idx_o`, and a lost restart on a repeated prefix leaves the start address one byte early. An address counter that slips is visible in `rec_pc_o` on every later record. The bench sweeps every byte value after each prefix and every displacement on both index registers, so a single misdecoded code point surfaces within one instruction.

// File: rtl/pfx_seq_pkg.sv
package pfx_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PG_BASE   = 3'd0,
    PG_BIT    = 3'd1,
    PG_EXT    = 3'd2,
    PG_IDX    = 3'd3,
    PG_IDXBIT = 3'd4
  } page_e;

  typedef enum logic [1:0] {
    IX_NONE = 2'd0,
    IX_A    = 2'd1,
    IX_B    = 2'd2
  } idx_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BIT, ST_EXT, ST_IDX, ST_DISP, ST_XOP
  } st_e;

  localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;
  localparam logic [BYTE_W-1:0] PFX_IA  = 8'hDD;
  localparam logic [BYTE_W-1:0] PFX_IB  = 8'hFD;
endpackage

// File: rtl/pfx_seq_fsm.sv
module pfx_seq_fsm
  import pfx_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              emit_o,
  output logic [ADDR_W-1:0] em_pc_o,
  output page_e             em_page_o,
  output idx_e              em_idx_o,
  output logic [BYTE_W-1:0] em_disp_o,
  output logic [BYTE_W-1:0] em_op_o,
  output logic [2:0]        em_len_o
);
  st_e               state_q, state_d;
  logic [ADDR_W-1:0] pc_q, start_q, start_d;
  idx_e              idx_q, idx_d;
  logic [BYTE_W-1:0] disp_q, disp_d;

  logic is_ix;
  assign is_ix = (byte_i == PFX_IA) || (byte_i == PFX_IB);

  always_comb begin
    state_d   = state_q;
    start_d   = start_q;
    idx_d     = idx_q;
    disp_d    = disp_q;
    emit_o    = 1'b0;
    em_page_o = PG_BASE;
    em_idx_o  = IX_NONE;
    em_disp_o = '0;
    em_op_o   = byte_i;
    em_len_o  = 3'd1;
    em_pc_o   = (state_q == ST_IDLE) ? pc_q : start_q;
    if (fire_i) begin
      case (state_q)
        ST_IDLE: begin
          start_d = pc_q;
          idx_d   = IX_NONE;
          disp_d  = '0;
          if (byte_i == PFX_BIT)      state_d = ST_BIT;
          else if (byte_i == PFX_EXT) state_d = ST_EXT;
          else if (is_ix) begin
            state_d = ST_IDX;
            idx_d   = (byte_i == PFX_IA) ? IX_A : IX_B;
          end else begin
            emit_o = 1'b1;
          end
        end
        ST_BIT: begin
          emit_o    = 1'b1;
          em_page_o = PG_BIT;
          em_len_o  = 3'd2;
          state_d   = ST_IDLE;
        end
        ST_EXT: begin
          if (byte_i == PFX_EXT) begin
            start_d = pc_q;  // restart at repeated prefix
          end else begin
            emit_o    = 1'b1;
            em_page_o = PG_EXT;
            em_len_o  = 3'd2;
            state_d   = ST_IDLE;
          end
        end
        ST_IDX: begin
          if (is_ix) begin
            start_d = pc_q;  // later prefix governs
            idx_d   = (byte_i == PFX_IA) ? IX_A : IX_B;
          end else if (byte_i == PFX_BIT) begin
            state_d = ST_DISP;
          end else begin
            emit_o    = 1'b1;
            em_page_o = PG_IDX;
            em_idx_o  = idx_q;
            em_len_o  = 3'd2;
            state_d   = ST_IDLE;
          end
        end
        ST_DISP: begin
          disp_d  = byte_i;
          state_d = ST_XOP;
        end
        ST_XOP: begin
          emit_o    = 1'b1;
          em_page_o = PG_IDXBIT;
          em_idx_o  = idx_q;
          em_disp_o = disp_q;
          em_len_o  = 3'd4;
          state_d   = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= RESET_PC;
      start_q <= RESET_PC;
      idx_q   <= IX_NONE;
      disp_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      idx_q   <= idx_d;
      disp_q  <= disp_d;
      if (fire_i) pc_q <= pc_q + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/pfx_seq_legal.sv
module pfx_seq_legal
  import pfx_seq_pkg::*;
(
  input  page_e             page_i,
  input  logic [BYTE_W-1:0] op_i,
  output logic              illegal_o
);
  logic known;
  // extended page: register/io block, or block-transfer group
  assign known     = (op_i[7:6] == 2'b01) || ((op_i[7:5] == 3'b101) && !op_i[2]);
  assign illegal_o = (page_i == PG_EXT) && !known;
endmodule

// File: rtl/pfx_seq_ea.sv
module pfx_seq_ea
  import pfx_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [2:0]        page_i,
  input  logic [1:0]        idx_i,
  input  logic [BYTE_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] idx_a_i,
  input  logic [ADDR_W-1:0] idx_b_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned EXT_W = ADDR_W - BYTE_W;
  logic [ADDR_W-1:0] base, offs;
  assign base = (idx_i == IX_B) ? idx_b_i : idx_a_i;
  assign offs = {{EXT_W{disp_i[BYTE_W-1]}}, disp_i};
  assign ea_o = (page_i == PG_IDXBIT) ? base + offs : '0;
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
  import pfx_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [ADDR_W-1:0] idx_a_i,
  input  logic [ADDR_W-1:0] idx_b_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [ADDR_W-1:0] rec_pc_o,
  output logic [2:0]        rec_page_o,
  output logic [1:0]        rec_idx_o,
  output logic [7:0]        rec_disp_o,
  output logic [7:0]        rec_op_o,
  output logic [2:0]        rec_len_o,
  output logic              rec_illegal_o,
  output logic [ADDR_W-1:0] rec_ea_o
);
  logic              fire, emit, ill;
  logic [ADDR_W-1:0] em_pc;
  page_e             em_page;
  idx_e              em_idx;
  logic [BYTE_W-1:0] em_disp, em_op;
  logic [2:0]        em_len;

  assign byte_ready_o = !rec_valid_o || rec_ready_i;
  assign fire         = byte_valid_i && byte_ready_o;

  pfx_seq_fsm #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) fsm_i (
    .clk_i, .rst_ni, .fire_i(fire), .byte_i,
    .emit_o(emit), .em_pc_o(em_pc), .em_page_o(em_page), .em_idx_o(em_idx),
    .em_disp_o(em_disp), .em_op_o(em_op), .em_len_o(em_len)
  );

  pfx_seq_legal legal_i (.page_i(em_page), .op_i(em_op), .illegal_o(ill));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_valid_o   <= 1'b0;
      rec_pc_o      <= '0;
      rec_page_o    <= '0;
      rec_idx_o     <= '0;
      rec_disp_o    <= '0;
      rec_op_o      <= '0;
      rec_len_o     <= '0;
      rec_illegal_o <= 1'b0;
    end else if (emit) begin
      rec_valid_o   <= 1'b1;
      rec_pc_o      <= em_pc;
      rec_page_o    <= em_page;
      rec_idx_o     <= em_idx;
      rec_disp_o    <= em_disp;
      rec_op_o      <= em_op;
      rec_len_o     <= em_len;
      rec_illegal_o <= ill;
    end else if (rec_ready_i) begin
      rec_valid_o   <= 1'b0;
    end
  end

  pfx_seq_ea #(.ADDR_W(ADDR_W)) ea_i (
    .page_i(rec_page_o), .idx_i(rec_idx_o), .disp_i(rec_disp_o),
    .idx_a_i, .idx_b_i, .ea_o(rec_ea_o)
  );
endmodule

// File: rtl/pfx_seq_chk.sv
module pfx_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_ready_o,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [ADDR_W-1:0] rec_pc_o,
  input logic [2:0]        rec_page_o,
  input logic [1:0]        rec_idx_o,
  input logic [7:0]        rec_op_o,
  input logic [2:0]        rec_len_o,
  input logic              rec_illegal_o,
  input logic [ADDR_W-1:0] rec_ea_o
);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_pc_o) &&
      $stable(rec_op_o) && $stable(rec_page_o) && $stable(rec_len_o));

  a_r11_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |-> !byte_ready_o);

  a_r2_base_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_page_o == 3'd0 |-> rec_len_o == 3'd1 && rec_idx_o == 2'd0);

  a_r8_xbit_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_page_o == 3'd4 |-> rec_len_o == 3'd4 && rec_idx_o != 2'd0);

  a_r6_idx_pages: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_page_o < 3'd3 |-> rec_idx_o == 2'd0);

  a_r12_ill_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_illegal_o |-> rec_page_o == 3'd2);

  a_r9_ea_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_page_o != 3'd4 |-> rec_ea_o == '0);
endmodule

bind pfx_seq pfx_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i, .rst_ni, .byte_ready_o, .rec_valid_o, .rec_ready_i, .rec_pc_o,
  .rec_page_o, .rec_idx_o, .rec_op_o, .rec_len_o, .rec_illegal_o, .rec_ea_o
);

// File: tb/pfx_seq_tb_top.sv
`timescale 1ns/1ps
module pfx_seq_tb_top;
  localparam int unsigned AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          byte_valid_i = 1'b0;
  logic          byte_ready_o;
  logic [AW-1:0] idx_a_i = 16'h1000;
  logic [AW-1:0] idx_b_i = 16'hFFF0;
  logic          rec_valid_o;
  logic          rec_ready_i = 1'b1;
  logic [AW-1:0] rec_pc_o;
  logic [2:0]    rec_page_o;
  logic [1:0]    rec_idx_o;
  logic [7:0]    rec_disp_o;
  logic [7:0]    rec_op_o;
  logic [2:0]    rec_len_o;
  logic          rec_illegal_o;
  logic [AW-1:0] rec_ea_o;

  always #2 clk_i = ~clk_i;

  pfx_seq #(.ADDR_W(AW)) dut_i (.*);

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [2:0]    page;
    logic [1:0]    idx;
    logic [7:0]    disp;
    logic [7:0]    op;
    logic [2:0]    len;
    logic          ill;
    logic [AW-1:0] ea;
  } rec_t;

  rec_t          got_q[$];
  int            n_run = 0;
  int            n_fail = 0;
  logic [AW-1:0] tb_pc = '0;

  always @(negedge clk_i)
    if (rst_ni && rec_valid_o && rec_ready_i)
      got_q.push_back('{rec_pc_o, rec_page_o, rec_idx_o, rec_disp_o, rec_op_o,
                        rec_len_o, rec_illegal_o, rec_ea_o});

  task automatic feed(input logic [7:0] b);
    logic ok;
    byte_i = b;
    byte_valid_i = 1'b1;
    forever begin
      ok = byte_ready_o;
      @(posedge clk_i);
      @(negedge clk_i);
      if (ok) break;
    end
    byte_valid_i = 1'b0;
    tb_pc = tb_pc + 16'd1;
  endtask

  task automatic expect_rec(input string req, input rec_t e);
    rec_t g;
    @(negedge clk_i);
    n_run++;
    if (got_q.size() == 0) begin
      n_fail++;
      $display("FAIL %s: no record, expected %h", req, e);
    end else begin
      g = got_q.pop_front();
      if (g !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", req, g, e);
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ext_ill(input logic [7:0] b);
    int v = int'(b);
    return !((v / 64 == 1) || (v / 32 == 5 && (v % 8) < 4));
  endfunction

  function automatic logic [AW-1:0] ea_of(input logic [AW-1:0] r, input logic [7:0] d);
    int s = (d >= 8'd128) ? int'(d) - 256 : int'(d);
    return AW'((int'(r) + s + 65536) % 65536);
  endfunction

  function automatic logic is_pfx(input logic [7:0] b);
    return b == 8'hCB || b == 8'hED || b == 8'hDD || b == 8'hFD;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    logic [AW-1:0] s;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 valid", 32'(rec_valid_o), 0);
    chk("R1 ready", 32'(byte_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 / R10 / R1 : base page sweep, first address is 0
    for (int b = 0; b < 256; b++) begin
      if (is_pfx(8'(b))) continue;
      s = tb_pc;
      feed(8'(b));
      expect_rec("R2 R10 base", '{s, 3'd0, 2'd0, 8'd0, 8'(b), 3'd1, 1'b0, 16'd0});
    end

    // R3: bit page sweep
    for (int b = 0; b < 256; b++) begin
      s = tb_pc;
      feed(8'hCB); feed(8'(b));
      expect_rec("R3 bit page", '{s, 3'd1, 2'd0, 8'd0, 8'(b), 3'd2, 1'b0, 16'd0});
    end

    // R4 / R12: extended page sweep with illegal decode
    for (int b = 0; b < 256; b++) begin
      if (b == 'hED) continue;
      s = tb_pc;
      feed(8'hED); feed(8'(b));
      expect_rec("R4 R12 ext page", '{s, 3'd2, 2'd0, 8'd0, 8'(b), 3'd2, ext_ill(8'(b)), 16'd0});
    end
    // R4: byte after an illegal one starts fresh
    s = tb_pc; feed(8'hED); feed(8'h00);
    expect_rec("R4 illegal", '{s, 3'd2, 2'd0, 8'd0, 8'h00, 3'd2, 1'b1, 16'd0});
    s = tb_pc; feed(8'h3C);
    expect_rec("R4 resume", '{s, 3'd0, 2'd0, 8'd0, 8'h3C, 3'd1, 1'b0, 16'd0});

    // R5: repeated extended prefix
    feed(8'hED); s = tb_pc; feed(8'hED); feed(8'h44);
    expect_rec("R5 ext restart", '{s, 3'd2, 2'd0, 8'd0, 8'h44, 3'd2, 1'b0, 16'd0});
    feed(8'hED); feed(8'hED); s = tb_pc; feed(8'hED); feed(8'hB0);
    expect_rec("R5 triple ext", '{s, 3'd2, 2'd0, 8'd0, 8'hB0, 3'd2, 1'b0, 16'd0});

    // R6: indexed page, both index prefixes
    for (int b = 0; b < 256; b++) begin
      if (b == 'hDD || b == 'hFD || b == 'hCB) continue;
      s = tb_pc; feed(8'hDD); feed(8'(b));
      expect_rec("R6 index 1", '{s, 3'd3, 2'd1, 8'd0, 8'(b), 3'd2, 1'b0, 16'd0});
      s = tb_pc; feed(8'hFD); feed(8'(b));
      expect_rec("R6 index 2", '{s, 3'd3, 2'd2, 8'd0, 8'(b), 3'd2, 1'b0, 16'd0});
    end

    // R7: prefix chains
    feed(8'hDD); s = tb_pc; feed(8'hFD); feed(8'h21);
    expect_rec("R7 dd fd", '{s, 3'd3, 2'd2, 8'd0, 8'h21, 3'd2, 1'b0, 16'd0});
    feed(8'hFD); s = tb_pc; feed(8'hDD); feed(8'h21);
    expect_rec("R7 fd dd", '{s, 3'd3, 2'd1, 8'd0, 8'h21, 3'd2, 1'b0, 16'd0});
    feed(8'hDD); feed(8'hDD); s = tb_pc; feed(8'hFD); feed(8'hCB); feed(8'h05); feed(8'h46);
    expect_rec("R7 chain to xbit", '{s, 3'd4, 2'd2, 8'h05, 8'h46, 3'd4, 1'b0, ea_of(idx_b_i, 8'h05)});

    // R8 / R9: indexed bit ops over every displacement
    for (int d = 0; d < 256; d++) begin
      s = tb_pc; feed(8'hDD); feed(8'hCB); feed(8'(d)); feed(8'(255 - d));
      expect_rec("R8 R9 xbit a", '{s, 3'd4, 2'd1, 8'(d), 8'(255 - d), 3'd4, 1'b0, ea_of(idx_a_i, 8'(d))});
      s = tb_pc; feed(8'hFD); feed(8'hCB); feed(8'(d)); feed(8'hC6);
      expect_rec("R8 R9 xbit b", '{s, 3'd4, 2'd2, 8'(d), 8'hC6, 3'd4, 1'b0, ea_of(idx_b_i, 8'(d))});
    end
    // R9: wrap at top and bottom of address space
    idx_a_i = 16'hFFFF; idx_b_i = 16'h0000;
    s = tb_pc; feed(8'hDD); feed(8'hCB); feed(8'h01); feed(8'h06);
    expect_rec("R9 wrap up", '{s, 3'd4, 2'd1, 8'h01, 8'h06, 3'd4, 1'b0, 16'h0000});
    s = tb_pc; feed(8'hFD); feed(8'hCB); feed(8'h80); feed(8'h06);
    expect_rec("R9 wrap down", '{s, 3'd4, 2'd2, 8'h80, 8'h06, 3'd4, 1'b0, 16'hFF80});

    // R11: backpressure
    rec_ready_i = 1'b0;
    s = tb_pc; feed(8'h77);
    repeat (3) @(negedge clk_i);
    chk("R11 valid held", 32'(rec_valid_o), 1);
    chk("R11 stall", 32'(byte_ready_o), 0);
    chk("R11 pc held", 32'(rec_pc_o), 32'(s));
    chk("R11 op held", 32'(rec_op_o), 32'h77);
    rec_ready_i = 1'b1;
    expect_rec("R11 release", '{s, 3'd0, 2'd0, 8'd0, 8'h77, 3'd1, 1'b0, 16'd0});
    s = tb_pc; feed(8'h3E);
    expect_rec("R11 next", '{s, 3'd0, 2'd0, 8'd0, 8'h3E, 3'd1, 1'b0, 16'd0});

    repeat (2) @(negedge clk_i);
    chk("R10 no stray records", 32'(got_q.size()), 0);
    summary();
  end
endmodule